// File: doc/BRIEF.md
# Three-Level Hierarchical Queue Scheduler

This block chooses which of 256 output queues on one egress port is served next. The queues are arranged as a tree. Thirty-two first-level nodes each pick one of eight queues. Four second-level nodes each pick one of eight first-level winners. A single top node picks one of the four second-level winners. A register holds the result of each level before the next level sees it, so a change at the inputs shows at the output three clock cycles later.

Each level is set on its own to strict priority or weighted round robin. Every first-level node also carries a service count that is cleared by a periodic tick. That count gives the node a ceiling, above which it is hidden from selection. It also gives a floor, below which the node is preferred over its siblings. The dequeue logic pulses `deq_i` when it takes the presented queue. The scheduler then moves its round-robin state along the served path and bumps the node's count.

Top module: `hq_sched`

## Requirements
- R1: While reset is asserted, `sel_vld_o` is low and `sel_q_o` is zero.
- R2: When no queue is flagged busy, `sel_vld_o` is low and `sel_q_o` is zero. A `deq_i` pulse in that state changes no pointer, credit or count.
- R3: Every queue presented with `sel_vld_o` high was busy three cycles earlier. A stable input pattern is fully reflected at the output three cycles after it is applied.
- R4: The queue index is `{top child[1:0], second-level child[2:0], first-level child[2:0]}`. The first-level node number is bit 7 down to bit 3 of the index.
- R5: At a strict-priority level, the eligible child with the lowest index wins.
- R6: At a weighted level, the child under the pointer is served again on each dequeue until it has been served as many times as its weight, and a weight of 0 counts as 1. The pointer then moves one past that child. If the child under the pointer is not eligible, the first eligible child found while wrapping upward from the pointer is served, and its count starts afresh.
- R7: Pointers and credits change only on a `deq_i` that arrives while `sel_vld_o` is high, and only for the nodes on the path of the presented queue. A strict level never moves its pointer.
- R8: A first-level node whose service count has reached its nonzero maximum limit is not eligible until the next tick. A maximum limit of 0 means no limit.
- R9: Within a second-level node, first-level children whose service count is below their minimum limit are chosen ahead of the other eligible children.
- R10: `tick_i` clears every first-level service count. When a tick and a dequeue arrive in the same cycle, the clear takes effect.
- R11: `lvl_rr_i[0]` selects the mode of the first level, bit 1 the second level and bit 2 the top level (1 = weighted, 0 = strict).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_busy_i | input | 256 | Per-queue non-empty flag |
| q_wt_i | input | 256*WW | Per-queue weight used by first-level nodes |
| n1_wt_i | input | 32*WW | Per first-level-node weight used by second-level nodes |
| n2_wt_i | input | 4*WW | Per second-level-node weight used by the top node |
| lvl_rr_i | input | 3 | Per-level mode, 1 = weighted round robin |
| min_lim_i | input | 32*CW | Per first-level-node minimum service count |
| max_lim_i | input | 32*CW | Per first-level-node maximum service count, 0 = unlimited |
| tick_i | input | 1 | Clears all service counts |
| deq_i | input | 1 | Presented queue has been taken |
| sel_q_o | output | 8 | Selected queue index |
| sel_vld_o | output | 1 | Selected index is valid |

## Verification
Pointer and credit state cannot be seen at the ports. It only shows when it changes which queue wins, and a wrong winner shows three cycles after the dequeue that caused it. The bench holds the busy pattern steady and pulses single dequeues. It waits past the pipeline depth before each comparison. That way every weighted walk, ceiling hit and floor preference shows up as a definite index. An ignored dequeue on an idle tree is exposed by arranging the next busy pattern so that a moved pointer would pick a different queue.

// File: rtl/hq_sched.sv
module hq_sched #(
  parameter int WW = 3,
  parameter int CW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [255:0]      q_busy_i,
  input  logic [256*WW-1:0] q_wt_i,
  input  logic [32*WW-1:0]  n1_wt_i,
  input  logic [4*WW-1:0]   n2_wt_i,
  input  logic [2:0]        lvl_rr_i,
  input  logic [32*CW-1:0]  min_lim_i,
  input  logic [32*CW-1:0]  max_lim_i,
  input  logic              tick_i,
  input  logic              deq_i,
  output logic [7:0]        sel_q_o,
  output logic              sel_vld_o
);
  localparam int N1 = 32;
  localparam int N2 = 4;
  localparam int SW = WW + 3;

  function automatic logic [3:0] pick8(input logic [7:0] el, input logic [2:0] st);
    logic [2:0] ix;
    pick8 = '0;
    for (int k = 7; k >= 0; k--) begin
      ix = st + 3'(k);
      if (el[ix]) pick8 = {1'b1, ix};
    end
  endfunction

  function automatic logic [SW-1:0] step(input logic [2:0] ptr, input logic [WW-1:0] cnt,
                                         input logic [2:0] w, input logic [WW-1:0] wt);
    logic [WW:0] n;
    n = ((w == ptr) ? {1'b0, cnt} : '0) + (WW+1)'(1);
    if (n >= {1'b0, wt}) step = {w + 3'd1, {WW{1'b0}}};
    else                 step = {w, n[WW-1:0]};
  endfunction

  logic [2:0]    p1  [N1];
  logic [WW-1:0] c1  [N1];
  logic [2:0]    p2  [N2];
  logic [WW-1:0] c2  [N2];
  logic [1:0]    p3;
  logic [WW-1:0] c3;
  logic [CW-1:0] svc [N1];

  logic [N1-1:0] s1v;
  logic [2:0]    s1i [N1];
  logic [N2-1:0] s2v;
  logic [5:0]    s2i [N2];

  logic [3:0]    pk1 [N1];
  logic [3:0]    pk2 [N2];
  logic [3:0]    pk3;
  logic [N1-1:0] ok1, urg;
  logic [7:0]    cand;

  always_comb begin
    cand = '0;
    for (int n = 0; n < N1; n++)
      pk1[n] = pick8(q_busy_i[n*8 +: 8], lvl_rr_i[0] ? p1[n] : 3'd0);
    for (int n = 0; n < N1; n++) begin
      ok1[n] = s1v[n] && (max_lim_i[n*CW +: CW] == '0 || svc[n] < max_lim_i[n*CW +: CW]);
      urg[n] = ok1[n] && (svc[n] < min_lim_i[n*CW +: CW]);
    end
    for (int g = 0; g < N2; g++) begin
      cand   = (|urg[g*8 +: 8]) ? urg[g*8 +: 8] : ok1[g*8 +: 8];
      pk2[g] = pick8(cand, lvl_rr_i[1] ? p2[g] : 3'd0);
    end
    pk3 = pick8({4'b0, s2v}, lvl_rr_i[2] ? {1'b0, p3} : 3'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1v       <= '0;
      s2v       <= '0;
      sel_vld_o <= 1'b0;
      sel_q_o   <= '0;
      for (int n = 0; n < N1; n++) s1i[n] <= '0;
      for (int g = 0; g < N2; g++) s2i[g] <= '0;
    end else begin
      for (int n = 0; n < N1; n++) begin
        s1v[n] <= pk1[n][3];
        s1i[n] <= pk1[n][2:0];
      end
      for (int g = 0; g < N2; g++) begin
        s2v[g] <= pk2[g][3];
        s2i[g] <= {pk2[g][2:0], s1i[g*8 + int'(pk2[g][2:0])]};
      end
      sel_vld_o <= pk3[3];
      sel_q_o   <= pk3[3] ? {pk3[1:0], s2i[pk3[1:0]]} : 8'd0;
    end
  end

  logic          acc;
  logic [4:0]    an;
  logic [1:0]    ag;
  logic [SW-1:0] st1, st2, st3;

  assign acc = deq_i && sel_vld_o;
  assign an  = sel_q_o[7:3];
  assign ag  = sel_q_o[7:6];
  assign st1 = step(p1[an], c1[an], sel_q_o[2:0], q_wt_i[sel_q_o*WW +: WW]);
  assign st2 = step(p2[ag], c2[ag], sel_q_o[5:3], n1_wt_i[an*WW +: WW]);
  assign st3 = step({1'b0, p3}, c3, {1'b0, ag}, n2_wt_i[ag*WW +: WW]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p3 <= '0;
      c3 <= '0;
      for (int n = 0; n < N1; n++) begin
        p1[n]  <= '0;
        c1[n]  <= '0;
        svc[n] <= '0;
      end
      for (int g = 0; g < N2; g++) begin
        p2[g] <= '0;
        c2[g] <= '0;
      end
    end else begin
      if (acc && lvl_rr_i[0]) begin
        p1[an] <= st1[SW-1:WW];
        c1[an] <= st1[WW-1:0];
      end
      if (acc && lvl_rr_i[1]) begin
        p2[ag] <= st2[SW-1:WW];
        c2[ag] <= st2[WW-1:0];
      end
      if (acc && lvl_rr_i[2]) begin
        p3 <= st3[WW+1:WW];
        c3 <= st3[WW-1:0];
      end
      if (tick_i) begin
        for (int n = 0; n < N1; n++) svc[n] <= '0;
      end else if (acc && svc[an] != '1) begin
        svc[an] <= svc[an] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hq_sched_chk.sv
module hq_sched_chk #(
  parameter int CW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [255:0]     q_busy_i,
  input logic [2:0]       lvl_rr_i,
  input logic [32*CW-1:0] min_lim_i,
  input logic [32*CW-1:0] max_lim_i,
  input logic [7:0]       sel_q_o,
  input logic             sel_vld_o
);
  logic [255:0] b1, b2, b3;
  logic         k1, k2, k3;
  logic         plain;
  logic [7:0]   low;

  assign plain = (lvl_rr_i == 3'b000) && (max_lim_i == '0) && (min_lim_i == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b1 <= '0; b2 <= '0; b3 <= '0;
      k1 <= 1'b0; k2 <= 1'b0; k3 <= 1'b0;
    end else begin
      b1 <= q_busy_i; b2 <= b1; b3 <= b2;
      k1 <= plain; k2 <= k1; k3 <= k2;
    end
  end

  always_comb begin
    low = '0;
    for (int i = 255; i >= 0; i--) if (b3[i]) low = 8'(i);
  end

  assert_served_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld_o |-> b3[sel_q_o]);

  assert_idle_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (b3 == '0) |-> !sel_vld_o);

  assert_zero_when_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_vld_o |-> (sel_q_o == 8'd0));

  assert_strict_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (plain && k1 && k2 && k3 && b3 != '0) |-> (sel_vld_o && sel_q_o == low));
endmodule

bind hq_sched hq_sched_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_busy_i(q_busy_i), .lvl_rr_i(lvl_rr_i),
  .min_lim_i(min_lim_i), .max_lim_i(max_lim_i),
  .sel_q_o(sel_q_o), .sel_vld_o(sel_vld_o)
);

// File: tb/hq_sched_bench.sv
module hq_sched_bench;
  localparam int WW = 3;
  localparam int CW = 4;
  localparam int SW = WW + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [255:0]      busy = '0;
  logic [256*WW-1:0] qwt = '0;
  logic [32*WW-1:0]  n1wt = '0;
  logic [4*WW-1:0]   n2wt = '0;
  logic [2:0]        rr = '0;
  logic [32*CW-1:0]  minl = '0;
  logic [32*CW-1:0]  maxl = '0;
  logic tick = 1'b0;
  logic deq = 1'b0;
  logic [7:0] sel_q;
  logic sel_vld;

  always #2 clk = ~clk;

  hq_sched #(.WW(WW), .CW(CW)) u_hq_sched (
    .clk(clk), .rst_n(rst_n), .q_busy_i(busy), .q_wt_i(qwt), .n1_wt_i(n1wt),
    .n2_wt_i(n2wt), .lvl_rr_i(rr), .min_lim_i(minl), .max_lim_i(maxl),
    .tick_i(tick), .deq_i(deq), .sel_q_o(sel_q), .sel_vld_o(sel_vld)
  );

  typedef struct { bit v; logic [7:0] q; string tag; } exp_t;
  exp_t sb[$];
  event smp;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [2:0]    mp1 [32];
  logic [WW-1:0] mc1 [32];
  logic [2:0]    mp2 [4];
  logic [WW-1:0] mc2 [4];
  logic [2:0]    mp3;
  logic [WW-1:0] mc3;
  int            msv [32];

  function automatic logic [3:0] bpick(input logic [7:0] el, input logic [2:0] st);
    for (int k = 0; k < 8; k++) if (el[3'(st + 3'(k))]) return {1'b1, 3'(st + 3'(k))};
    return 4'd0;
  endfunction

  function automatic logic [SW-1:0] badv(input logic [2:0] ptr, input logic [WW-1:0] cnt,
                                         input logic [2:0] w, input logic [WW-1:0] wt);
    int n;
    n = (w == ptr) ? int'(cnt) + 1 : 1;
    if (n >= int'(wt)) return {3'(w + 3'd1), {WW{1'b0}}};
    return {w, WW'(n)};
  endfunction

  task automatic mexp(output bit v, output logic [7:0] q);
    logic [3:0] a [32];
    logic [3:0] b [4];
    logic [3:0] c;
    logic [7:0] ok, ur, cd;
    int mx, mn;
    for (int n = 0; n < 32; n++) a[n] = bpick(busy[n*8 +: 8], rr[0] ? mp1[n] : 3'd0);
    for (int g = 0; g < 4; g++) begin
      ok = '0; ur = '0;
      for (int k = 0; k < 8; k++) begin
        mx = int'(maxl[(g*8+k)*CW +: CW]);
        mn = int'(minl[(g*8+k)*CW +: CW]);
        ok[k] = a[g*8+k][3] && (mx == 0 || msv[g*8+k] < mx);
        ur[k] = ok[k] && msv[g*8+k] < mn;
      end
      cd = (ur != 0) ? ur : ok;
      b[g] = bpick(cd, rr[1] ? mp2[g] : 3'd0);
    end
    c = bpick({4'b0, b[0][3], b[1][3], b[2][3], b[3][3]} == 8'd0 ? 8'd0 :
              {4'b0, b[3][3], b[2][3], b[1][3], b[0][3]}, rr[2] ? mp3 : 3'd0);
    v = c[3];
    q = v ? {c[1:0], b[c[1:0]][2:0], a[{c[1:0], b[c[1:0]][2:0]}][2:0]} : 8'd0;
  endtask

  task automatic settle_check(input string tag);
    exp_t e;
    repeat (4) @(posedge clk);
    @(negedge clk);
    mexp(e.v, e.q);
    e.tag = tag;
    sb.push_back(e);
    -> smp;
    #1;
  endtask

  task automatic do_deq(input string tag);
    bit v;
    logic [7:0] q;
    logic [SW-1:0] r;
    mexp(v, q);
    @(negedge clk);
    deq = 1'b1;
    @(negedge clk);
    deq = 1'b0;
    if (v) begin
      if (rr[0]) begin
        r = badv(mp1[q[7:3]], mc1[q[7:3]], q[2:0], qwt[q*WW +: WW]);
        mp1[q[7:3]] = r[SW-1:WW]; mc1[q[7:3]] = r[WW-1:0];
      end
      if (rr[1]) begin
        r = badv(mp2[q[7:6]], mc2[q[7:6]], q[5:3], n1wt[q[7:3]*WW +: WW]);
        mp2[q[7:6]] = r[SW-1:WW]; mc2[q[7:6]] = r[WW-1:0];
      end
      if (rr[2]) begin
        r = badv(mp3, mc3, {1'b0, q[7:6]}, n2wt[q[7:6]*WW +: WW]);
        mp3 = {1'b0, r[WW+1:WW]}; mc3 = r[WW-1:0];
      end
      if (msv[q[7:3]] < (1 << CW) - 1) msv[q[7:3]]++;
    end
    settle_check(tag);
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    for (int n = 0; n < 32; n++) msv[n] = 0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(smp);
      e = sb.pop_front();
      checks++;
      if (sel_vld !== e.v || sel_q !== e.q) begin
        fails++;
        $display("FAIL %s: got vld=%0b q=%0d, expected vld=%0b q=%0d",
                 e.tag, sel_vld, sel_q, e.v, e.q);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    exp_t e;
    for (int n = 0; n < 32; n++) begin mp1[n] = 0; mc1[n] = 0; msv[n] = 0; end
    for (int g = 0; g < 4; g++) begin mp2[g] = 0; mc2[g] = 0; end
    mp3 = 0; mc3 = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    busy[3] = 1'b1;
    repeat (2) @(negedge clk);
    e.v = 0; e.q = 0; e.tag = "R1 reset";
    sb.push_back(e); -> smp; #1;
    busy = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // R5 R11 R4: all strict
    busy[5] = 1; busy[9] = 1; busy[200] = 1;
    settle_check("R5 strict lowest");
    do_deq("R5 R7 strict no move");
    @(negedge clk); busy[5] = 0;
    settle_check("R5 R4 next node");
    @(negedge clk); busy = '0; busy[200] = 1;
    settle_check("R4 R3 top-level path");

    // R2: idle tree, dequeues ignored even in weighted mode
    @(negedge clk); busy = '0; rr = 3'b111;
    qwt[0*WW +: WW] = 1;
    settle_check("R2 idle invalid");
    do_deq("R2 idle deq");
    do_deq("R2 idle deq again");
    @(negedge clk); busy[0] = 1; busy[1] = 1;
    settle_check("R2 R7 pointer unmoved");

    // R6: weighted first level
    @(negedge clk); rr = 3'b001; busy = '0;
    busy[1] = 1; busy[3] = 1; busy[4] = 1;
    qwt[1*WW +: WW] = 2; qwt[3*WW +: WW] = 1; qwt[4*WW +: WW] = 3;
    settle_check("R6 L1 start");
    for (int i = 0; i < 8; i++) do_deq("R6 L1 walk");
    @(negedge clk); qwt[3*WW +: WW] = 0;
    for (int i = 0; i < 4; i++) do_deq("R6 zero weight");

    // R6 R11: weighted second and top levels
    @(negedge clk); rr = 3'b110; busy = '0;
    busy[1] = 1; busy[17] = 1; busy[70] = 1; busy[130] = 1; busy[250] = 1;
    n1wt[2*WW +: WW] = 2; n2wt[0 +: WW] = 2; n2wt[2*WW +: WW] = 3;
    settle_check("R11 L2 L3 start");
    for (int i = 0; i < 10; i++) do_deq("R6 R11 upper walk");

    // R8 R10: maximum ceiling
    @(negedge clk); rr = 3'b000; busy = '0; busy[0] = 1; busy[8] = 1;
    maxl[0 +: CW] = 2;
    do_tick();
    settle_check("R8 below ceiling");
    do_deq("R8 first");
    do_deq("R8 reaches ceiling");
    do_deq("R8 masked");
    do_tick();
    settle_check("R10 refill");

    // R9: minimum floor
    @(negedge clk); maxl = '0; minl[1*CW +: CW] = 2;
    do_tick();
    settle_check("R9 floor precedence");
    do_deq("R9 still below");
    do_deq("R9 floor met");
    settle_check("R9 back to strict");

    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule